// File: doc/BRIEF.md
# POST Code Byte Reassembler

This block rebuilds multi-byte power-on self-test (POST) codes from a debug-port capture stream. Each captured host write deposits one data byte together with a two-bit byte offset into a 16-entry FIFO through a simple push interface. A single host transaction may deposit up to four bytes at offsets 0 through 3. Firmware or a sequencer requests a service pass with a one-cycle `drain_start` pulse. The block then pops the FIFO one entry per cycle and places each byte at its offset in a 32-bit accumulator.

A code boundary is not carried explicitly. It is inferred whenever the entry that follows the current one carries offset 0, so the bytes of one host transaction merge into one word. The last entry of a pass also closes the code in progress. Each finished code appears on `code` together with a one-cycle `code_valid` strobe.

Two sticky flags are kept, each cleared by driving a 1 on its clear input. One flags a push that was lost because the FIFO was full. The other flags that the host has written something since the flag was last cleared.

Top module: `post_code_assembler`

## Requirements
- R1: A FIFO entry carries an 8-bit data byte and a 2-bit offset. The byte is ORed into accumulator bits [8*offset+7 : 8*offset]. Repeated offsets within one code OR their bytes together.
- R2: A finished code is presented on the 32-bit `code` output with `code_valid` high for exactly one cycle. Byte lanes that received no entry read as zero.
- R3: While an entry is popped, if the following entry in the same pass has offset 0, the current code is emitted and the next entry starts a fresh, zeroed code.
- R4: The last entry of a pass always closes the code in progress, even when that code started at a nonzero offset. `drain_busy` falls on the same edge that raises the final `code_valid`.
- R5: A `drain_start` pulse while idle snapshots the FIFO fill level, capped at MAX_BATCH (16). That many entries are then drained at one per cycle. Entries pushed during the pass wait for a later pass. A pulse with an empty FIFO starts nothing.
- R6: The FIFO holds DEPTH (16) entries. A push that arrives while the FIFO is full is dropped and sets the overflow flag.
- R7: The overflow flag is sticky. It clears only in a cycle where `ovf_clr` is 1, and a new overflow in that same cycle keeps it set.
- R8: The host-write flag is set by every push and cleared by `pend_clr` = 1. A push in the same cycle as the clear wins.
- R9: After reset, `code_valid`, `drain_busy`, `ovf_flag` and `pend_flag` are 0 and the FIFO is empty.
- R10: Entries are drained in push order, and codes are emitted in the order their bytes were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push one captured byte into the FIFO |
| push_data | input | 8 | Captured data byte |
| push_offset | input | 2 | Byte position of the captured byte |
| drain_start | input | 1 | Pulse to start a service pass |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| pend_clr | input | 1 | Write-1 clear of the host-write flag |
| code_valid | output | 1 | One-cycle strobe for a finished code |
| code | output | 32 | Reassembled code |
| drain_busy | output | 1 | A service pass is in progress |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |
| pend_flag | output | 1 | Sticky host-write flag |

## Verification
The reassembly is tried with several offset patterns, each of which separates one rule from the others:
- single bytes, which expose lanes that are not zeroed;
- full ascending four-byte words, which check lane placement;
- out-of-order offsets, which check that placement follows the offset field and not arrival order;
- repeated offsets, which check OR merging;
- streams of offset-0 bytes, which check the boundary rule;
- a leading nonzero offset followed by offset 0, which separates the boundary rule from the end-of-pass rule.

A full FIFO with a push made during the pass shows that a pass stops at its snapshot count and closes a lone offset-1 byte on its own. An overfilled FIFO shows that the seventeenth byte is lost while the flag stays set until it is cleared.

// File: rtl/post_code_pkg.sv
package post_code_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFF_W  = 2;
  localparam int unsigned CODE_W = BYTE_W << OFF_W;

  typedef struct packed {
    logic [OFF_W-1:0]  lane;
    logic [BYTE_W-1:0] value;
  } pc_entry_t;
endpackage

// File: rtl/pc_sticky_flag.sv
module pc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  // Set has priority over a simultaneous write-1 clear.
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pc_capture_fifo.sv
module pc_capture_fifo
  import post_code_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  pc_entry_t                push_entry_i,
  input  logic                     pop_i,
  output pc_entry_t                head_o,
  output pc_entry_t                after_head_o,
  output logic [$clog2(DEPTH):0]   fill_o,
  output logic                     full_o,
  output logic                     empty_o,
  output logic                     drop_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             accept;
  logic             take;
  pc_entry_t        slots [DEPTH];

  assign full_o  = (fill_q == CNT_W'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign accept  = push_i && !full_o;
  assign drop_o  = push_i && full_o;
  assign take    = pop_i && !empty_o;

  // Storage: one register per slot, written only when the write pointer selects it.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    pc_entry_t slot_q;
    logic      slot_we;
    assign slot_we = accept && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q <= push_entry_i;
    end
    assign slots[g] = slot_q;
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    if (accept) wr_ptr_d = wr_ptr_q + 1'b1;
    if (take)   rd_ptr_d = rd_ptr_q + 1'b1;
    case ({accept, take})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  assign head_o       = slots[rd_ptr_q];
  assign after_head_o = slots[rd_ptr_q + 1'b1];
  assign fill_o       = fill_q;
endmodule

// File: rtl/pc_drain_engine.sv
module pc_drain_engine
  import post_code_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned MAX_BATCH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [$clog2(DEPTH):0] fill_i,
  input  pc_entry_t              head_i,
  input  pc_entry_t              after_head_i,
  output logic                   pop_o,
  output logic                   busy_o,
  output logic                   code_valid_o,
  output logic [CODE_W-1:0]      code_o
);
  localparam int unsigned CNT_W   = $clog2(DEPTH) + 1;
  localparam int unsigned BATCH_W = $clog2(MAX_BATCH + 1);

  logic               busy_q, busy_d;
  logic [BATCH_W-1:0] left_q, left_d;
  logic [CODE_W-1:0]  acc_q, acc_d;
  logic [CODE_W-1:0]  out_q, out_d;
  logic               vld_q, vld_d;
  logic [BATCH_W-1:0] snapshot;
  logic [CODE_W-1:0]  placed;
  logic [CODE_W-1:0]  merged;
  logic               final_entry;
  logic               close_code;

  assign snapshot = (fill_i > CNT_W'(MAX_BATCH)) ? BATCH_W'(MAX_BATCH)
                                                 : BATCH_W'(fill_i);

  assign placed      = CODE_W'(head_i.value) << {head_i.lane, 3'b000};
  assign merged      = acc_q | placed;
  assign final_entry = (left_q == BATCH_W'(1));
  assign close_code  = final_entry || (after_head_i.lane == '0);
  assign pop_o       = busy_q;

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    acc_d  = acc_q;
    out_d  = out_q;
    vld_d  = 1'b0;
    if (busy_q) begin
      left_d = left_q - 1'b1;
      if (close_code) begin
        out_d = merged;
        vld_d = 1'b1;
        acc_d = '0;
      end else begin
        acc_d = merged;
      end
      if (final_entry) busy_d = 1'b0;
    end else if (start_i && (snapshot != '0)) begin
      busy_d = 1'b1;
      left_d = snapshot;
      acc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      acc_q  <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
      acc_q  <= acc_d;
      out_q  <= out_d;
      vld_q  <= vld_d;
    end
  end

  assign busy_o       = busy_q;
  assign code_valid_o = vld_q;
  assign code_o       = out_q;
endmodule

// File: rtl/post_code_assembler.sv
module post_code_assembler
  import post_code_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned MAX_BATCH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [7:0]  push_data,
  input  logic [1:0]  push_offset,
  input  logic        drain_start,
  input  logic        ovf_clr,
  input  logic        pend_clr,
  output logic        code_valid,
  output logic [31:0] code,
  output logic        drain_busy,
  output logic        ovf_flag,
  output logic        pend_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  pc_entry_t        in_entry;
  pc_entry_t        head;
  pc_entry_t        after_head;
  logic [CNT_W-1:0] fill;
  logic             fifo_full;
  logic             fifo_empty;
  logic             fifo_drop;
  logic             pop;

  assign in_entry.lane  = push_offset;
  assign in_entry.value = push_data;

  pc_capture_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_valid),
    .push_entry_i (in_entry),
    .pop_i        (pop),
    .head_o       (head),
    .after_head_o (after_head),
    .fill_o       (fill),
    .full_o       (fifo_full),
    .empty_o      (fifo_empty),
    .drop_o       (fifo_drop)
  );

  pc_drain_engine #(.DEPTH(DEPTH), .MAX_BATCH(MAX_BATCH)) drain_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (drain_start),
    .fill_i       (fill),
    .head_i       (head),
    .after_head_i (after_head),
    .pop_o        (pop),
    .busy_o       (drain_busy),
    .code_valid_o (code_valid),
    .code_o       (code)
  );

  pc_sticky_flag ovf_flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fifo_drop),
    .clr_i  (ovf_clr),
    .flag_o (ovf_flag)
  );

  pc_sticky_flag pend_flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (push_valid),
    .clr_i  (pend_clr),
    .flag_o (pend_flag)
  );
endmodule

// File: rtl/post_code_assembler_chk.sv
module post_code_assembler_chk (
  input logic clk,
  input logic rst_n,
  input logic push_valid,
  input logic fifo_full,
  input logic fifo_empty,
  input logic pop,
  input logic drain_busy,
  input logic code_valid,
  input logic ovf_flag,
  input logic ovf_clr,
  input logic pend_flag
);
  // R6
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fifo_full) |=> ovf_flag);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R8
  push_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> pend_flag);

  // R5
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  // R4
  pass_end_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_busy) |-> code_valid);

  // R2
  strobe_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(drain_busy));
endmodule

bind post_code_assembler post_code_assembler_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .pop        (pop),
  .drain_busy (drain_busy),
  .code_valid (code_valid),
  .ovf_flag   (ovf_flag),
  .ovf_clr    (ovf_clr),
  .pend_flag  (pend_flag)
);

// File: tb/post_code_assembler_tb_top.sv
module post_code_assembler_tb_top;
  logic        clk;
  logic        rst_n;
  logic        push_valid;
  logic [7:0]  push_data;
  logic [1:0]  push_offset;
  logic        drain_start;
  logic        ovf_clr;
  logic        pend_clr;
  logic        code_valid;
  logic [31:0] code;
  logic        drain_busy;
  logic        ovf_flag;
  logic        pend_flag;

  int checks;
  int failures;
  int ng;
  bit done;
  logic [31:0] got [64];

  post_code_assembler dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .push_data   (push_data),
    .push_offset (push_offset),
    .drain_start (drain_start),
    .ovf_clr     (ovf_clr),
    .pend_clr    (pend_clr),
    .code_valid  (code_valid),
    .code        (code),
    .drain_busy  (drain_busy),
    .ovf_flag    (ovf_flag),
    .pend_flag   (pend_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Record every emitted code; sampled away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && code_valid && ng < 64) begin
      got[ng] = code;
      ng = ng + 1;
    end
  end

  typedef struct packed {
    logic [2:0]       n;
    logic [3:0][1:0]  off;
    logic [3:0][7:0]  dat;
    logic [2:0]       ne;
    logic [3:0][31:0] exp;
  } vec_t;

  // Index 0 of each packed list is the rightmost item.
  localparam vec_t VECS [8] = '{
    '{3'd1, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'h00,8'h00,8'hA5}, 3'd1,
      {32'h0,32'h0,32'h0,32'h000000A5}},
    '{3'd2, {2'd0,2'd0,2'd1,2'd0}, {8'h00,8'h00,8'h12,8'h34}, 3'd1,
      {32'h0,32'h0,32'h0,32'h00001234}},
    '{3'd4, {2'd3,2'd2,2'd1,2'd0}, {8'h12,8'h34,8'h56,8'h78}, 3'd1,
      {32'h0,32'h0,32'h0,32'h12345678}},
    '{3'd3, {2'd0,2'd1,2'd2,2'd0}, {8'h00,8'h22,8'h33,8'h11}, 3'd1,
      {32'h0,32'h0,32'h0,32'h00332211}},
    '{3'd3, {2'd0,2'd0,2'd0,2'd0}, {8'h00,8'hCC,8'hBB,8'hAA}, 3'd3,
      {32'h0,32'h000000CC,32'h000000BB,32'h000000AA}},
    '{3'd2, {2'd0,2'd0,2'd0,2'd1}, {8'h00,8'h00,8'h44,8'h99}, 3'd2,
      {32'h0,32'h0,32'h00000044,32'h00009900}},
    '{3'd3, {2'd0,2'd1,2'd1,2'd0}, {8'h00,8'h0F,8'hF0,8'h01}, 3'd1,
      {32'h0,32'h0,32'h0,32'h0000FF01}},
    '{3'd4, {2'd3,2'd0,2'd2,2'd0}, {8'hD4,8'hC3,8'hB2,8'hA1}, 3'd2,
      {32'h0,32'h0,32'hD40000C3,32'h00B200A1}}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks = checks + 1;
    if (act !== expv) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push_one(input logic [1:0] off, input logic [7:0] d);
    push_valid  = 1'b1;
    push_offset = off;
    push_data   = d;
    @(negedge clk);
    push_valid  = 1'b0;
  endtask

  task automatic run_pass();
    drain_start = 1'b1;
    @(negedge clk);
    drain_start = 1'b0;
    while (drain_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0; ng = 0; done = 0;
    rst_n = 1'b0; push_valid = 1'b0; push_data = '0; push_offset = '0;
    drain_start = 1'b0; ovf_clr = 1'b0; pend_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 code_valid", {31'b0, code_valid}, 32'd0);
    check("R9 drain_busy", {31'b0, drain_busy}, 32'd0);
    check("R9 ovf_flag", {31'b0, ovf_flag}, 32'd0);
    check("R9 pend_flag", {31'b0, pend_flag}, 32'd0);

    // R5 empty FIFO: a start pulse does nothing
    drain_start = 1'b1;
    @(negedge clk);
    drain_start = 1'b0;
    @(negedge clk);
    check("R5 empty start busy", {31'b0, drain_busy}, 32'd0);
    check("R5 empty start no code", ng, 0);

    // Vector table: R1 R2 R3 R10 placement, zero fill, boundaries, order
    for (int v = 0; v < 8; v++) begin
      int base;
      base = ng;
      for (int e = 0; e < int'(VECS[v].n); e++)
        push_one(VECS[v].off[e], VECS[v].dat[e]);
      @(negedge clk);
      run_pass();
      check($sformatf("R3 R10 vector %0d code count", v), ng - base, int'(VECS[v].ne));
      for (int k = 0; k < int'(VECS[v].ne); k++)
        check($sformatf("R1 R2 vector %0d code %0d", v, k), got[base + k], VECS[v].exp[k]);
    end

    // R8 host-write flag
    check("R8 pend set by pushes", {31'b0, pend_flag}, 32'd1);
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0;
    check("R8 pend cleared", {31'b0, pend_flag}, 32'd0);
    pend_clr = 1'b1;
    push_one(2'd0, 8'h66);
    pend_clr = 1'b0;
    check("R8 push wins over clear", {31'b0, pend_flag}, 32'd1);
    run_pass();

    // R5 R4 batch snapshot: 16 entries, one more pushed mid-pass
    begin
      int base;
      base = ng;
      for (int i = 0; i < 16; i++) push_one(2'd0, 8'(i));
      drain_start = 1'b1;
      @(negedge clk);
      drain_start = 1'b0;
      repeat (3) @(negedge clk);
      push_one(2'd1, 8'h5A);
      while (drain_busy) @(negedge clk);
      @(negedge clk);
      check("R5 pass drains snapshot only", ng - base, 16);
      check("R10 last code of pass", got[base + 15], 32'h0000000F);
      check("R6 no overflow mid-pass push", {31'b0, ovf_flag}, 32'd0);
      base = ng;
      run_pass();
      check("R4 lone offset-1 byte count", ng - base, 1);
      check("R4 lone offset-1 byte code", got[base], 32'h00005A00);
    end

    // R6 R7 overflow
    begin
      int base;
      for (int i = 0; i < 17; i++) push_one(2'd0, 8'(8'h80 + i));
      @(negedge clk);
      check("R6 overflow flag set", {31'b0, ovf_flag}, 32'd1);
      base = ng;
      run_pass();
      check("R6 dropped entry count", ng - base, 16);
      check("R6 last kept entry", got[base + 15], 32'h0000008F);
      check("R7 flag sticky after drain", {31'b0, ovf_flag}, 32'd1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      check("R7 flag cleared by write-1", {31'b0, ovf_flag}, 32'd0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule